// File: doc/BRIEF.md
# Command-Driven HDLC Frame Transmitter

This block is the transmit half of an HDLC link controller for a narrowband signalling channel. A processor fills a 64-byte transmit FIFO through byte writes on a simple write bus. It then controls framing by writing single-bit commands to a write-only command register. Command bits act only when written as one and leave nothing behind. Writing zero to a command bit has no effect.

On a start command the block sends an opening flag. It then serializes the FIFO bytes least significant bit first, inserting a zero after every five consecutive ones. After the last byte it appends the complemented CRC-16 and a closing flag. An external bit strobe `bit_en` paces the line, so one line bit is produced per strobe. Between frames the line carries continuous ones.

A reset command abandons the frame at once, flushes the FIFO and returns the line to ones. If the FIFO runs dry before an end command has arrived, the frame is aborted with a run of ones and a sticky underrun flag is raised.

Top module: `hdlc_cmd_tx`

## Requirements
- R1: After reset `tx_bit` is 1, `fifo_ready` is 1 and `underrun` is 0. While no frame is being sent, the line stays at 1 on every bit strobe.
- R2: Command writes go to address 0x02, where bit 0 = transmitter reset, bit 1 = end and bit 3 = start/continue. A command write with none of bits 0, 1 or 3 set changes neither the line nor the FIFO, whatever the other bits hold.
- R3: A write to address 0x02 with bits 3 and 1 both set starts a frame on the next bit strobe. The frame is the flag 0x7E, then the FIFO bytes in write order, each sent LSB first, then the CRC, then the flag 0x7E. Flags are sent LSB first: 0,1,1,1,1,1,1,0.
- R4: Between the flags, every run of five consecutive ones in the data and CRC bits is followed by an inserted 0, including a run that ends just before the closing flag. No zero is inserted inside the flags.
- R5: The CRC is CRC-16 with polynomial x^16+x^12+x^5+1, computed LSB first over the data bits from a preset of 0xFFFF. The ones complement of the result is sent LSB first. A frame with no data bytes carries sixteen zero CRC bits.
- R6: A write to address 0x02 with bit 0 set puts `tx_bit` to 1 on the following cycle. It also empties the FIFO, so `fifo_ready` becomes 1, clears `underrun`, and cancels any pending start or end.
- R7: `fifo_ready` is 1 exactly when the FIFO holds no byte. It is 0 while loaded bytes, including those of a frame in progress, are still unsent.
- R8: If the FIFO is empty at the end of a byte and no end command is pending, the block sends eight ones and returns to idle fill, and `underrun` becomes 1 and stays 1.
- R9: A start command written while the opening flag or data bytes are being sent acts only as a continue. It does not cause a further frame afterwards.
- R10: Bytes written to address 0x00 enter the FIFO. Writes to it beyond 64 held bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Write address: 0x00 FIFO data, 0x02 command |
| bus_wdata | input | 8 | Write data |
| bit_en | input | 1 | Line bit strobe, one line bit per pulse |
| tx_bit | output | 1 | Serial line output |
| fifo_ready | output | 1 | FIFO is empty and can take a full block |
| underrun | output | 1 | Sticky frame-abort flag |

## Verification
The assertions assume that the processor follows the command protocol. The FIFO is loaded only while the line is idle and the FIFO is empty. A new start is written only once the previous frame has fully left the line, or as a continue while data is being sent. The bench keeps to this by waiting for its own expected bit stream to drain before each new load or start. It issues the one continue write a few dozen bits into a long frame, where the block must be in its data phase. Bit strobes arrive every third cycle, so command writes land both on and between strobe edges.

// File: rtl/hdlc_cmd_tx.sv
module hdlc_cmd_tx #(
  parameter int          DEPTH     = 64,
  parameter logic [7:0]  CMD_ADDR  = 8'h02,
  parameter logic [7:0]  DATA_ADDR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bit_en,
  output logic       tx_bit,
  output logic       fifo_ready,
  output logic       underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] FLAG = 8'h7E;

  typedef enum logic [2:0] {S_IDLE, S_OFLAG, S_DATA, S_CRC, S_CFLAG, S_ABORT} st_t;

  st_t           state;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [7:0]    sh;
  logic [15:0]   crc;
  logic [3:0]    cnt;
  logic [2:0]    ones;
  logic          go, endp;

  wire cmd_wr = bus_we && bus_addr == CMD_ADDR;
  wire xrst   = cmd_wr && bus_wdata[0];
  wire xme    = cmd_wr && bus_wdata[1];
  wire xms    = cmd_wr && bus_wdata[3];
  wire full   = count == CW'(DEPTH);
  wire push   = bus_we && bus_addr == DATA_ADDR && !full;
  wire stuff  = ones == 3'd5 && (state == S_DATA || state == S_CRC || state == S_CFLAG);
  wire byte_end = bit_en && !xrst && cnt == 4'd7 &&
                  (state == S_OFLAG || (state == S_DATA && !stuff));
  wire pop    = byte_end && count != '0;
  wire dbit   = (state == S_DATA) ? sh[0] : crc[0];
  wire [15:0] crc_n = {1'b0, crc[15:1]} ^ ((crc[0] ^ sh[0]) ? 16'h8408 : 16'h0000);

  assign fifo_ready = count == '0;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n || xrst) begin
      state <= S_IDLE; tx_bit <= 1'b1; go <= 1'b0; endp <= 1'b0; underrun <= 1'b0;
      count <= '0; rd_ptr <= '0; wr_ptr <= '0; cnt <= '0; ones <= '0;
      sh <= '0; crc <= 16'hFFFF;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (bit_en) begin
        case (state)
          S_IDLE:
            if (go) begin
              tx_bit <= FLAG[0]; cnt <= 4'd1; state <= S_OFLAG; go <= 1'b0;
              ones <= '0; crc <= 16'hFFFF;
            end else tx_bit <= 1'b1;
          S_OFLAG: begin
            tx_bit <= FLAG[cnt[2:0]]; cnt <= cnt + 4'd1;
          end
          S_DATA, S_CRC:
            if (stuff) begin
              tx_bit <= 1'b0; ones <= '0;
            end else begin
              tx_bit <= dbit;
              ones   <= dbit ? ones + 3'd1 : '0;
              cnt    <= cnt + 4'd1;
              if (state == S_DATA) begin
                sh <= {1'b0, sh[7:1]}; crc <= crc_n;
              end else begin
                crc <= {1'b0, crc[15:1]};
                if (cnt == 4'd15) begin state <= S_CFLAG; cnt <= '0; end
              end
            end
          S_CFLAG:
            if (stuff) begin
              tx_bit <= 1'b0; ones <= '0;
            end else begin
              tx_bit <= FLAG[cnt[2:0]]; cnt <= cnt + 4'd1;
              if (cnt == 4'd7) state <= S_IDLE;
            end
          default: begin
            tx_bit <= 1'b1; cnt <= cnt + 4'd1;
            if (cnt == 4'd7) state <= S_IDLE;
          end
        endcase
      end
      if (pop) begin
        state <= S_DATA; sh <= mem[rd_ptr]; cnt <= '0;
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end else if (byte_end && endp) begin
        state <= S_CRC; cnt <= '0; endp <= 1'b0;
        crc <= ~((state == S_DATA) ? crc_n : crc);
      end else if (byte_end) begin
        state <= S_ABORT; cnt <= '0; underrun <= 1'b1;
      end
      if (xms && state != S_OFLAG && state != S_DATA) go <= 1'b1;
      if (xme) endp <= 1'b1;
    end
  end

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE && !go && bit_en |=> tx_bit);                              // R1
  AST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (bus_wdata & 8'h0B) == 8'h00 && !bit_en |=> $stable(state) && $stable(tx_bit)); // R2
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !xrst && (state == S_DATA || state == S_CRC) && ones == 3'd5 |=> !tx_bit); // R4
  AST_RESET_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    xrst |=> tx_bit && fifo_ready && !underrun);                               // R6
  AST_UNDERRUN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> state == S_ABORT);                                     // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop && !xrst |=> full);                                            // R10
endmodule

// File: tb/test_hdlc_cmd_tx.sv
module test_hdlc_cmd_tx;
  logic clk = 0, rst_n = 0, bus_we = 0, bit_en = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic tx_bit, fifo_ready, underrun;

  hdlc_cmd_tx i_hdlc_cmd_tx (.clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bit_en,
                             .tx_bit, .fifo_ready, .underrun);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit running = 0;
  bit exp_bit = 1;
  bit q[$];
  byte unsigned fq[$];
  int ones;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic put(bit b);
    if (ones == 5) begin q.push_back(1'b0); ones = 0; end
    q.push_back(b);
    ones = b ? ones + 1 : 0;
  endtask

  task automatic build(bit with_end);
    int crc = 16'hFFFF;
    for (int i = 0; i < 8; i++) q.push_back(i != 0 && i != 7);
    ones = 0;
    while (fq.size() > 0) begin
      byte unsigned d = fq.pop_front();
      for (int i = 0; i < 8; i++) begin
        bit b = d[i];
        bit fb = crc[0] ^ b;
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
        put(b);
      end
    end
    if (with_end) begin
      crc = ~crc & 16'hFFFF;
      for (int i = 0; i < 16; i++) put(crc[i]);
      if (ones == 5) q.push_back(1'b0);
      for (int i = 0; i < 8; i++) q.push_back(i != 0 && i != 7);
    end else
      for (int i = 0; i < 8; i++) q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_bit = 1; q.delete(); fq.delete();
    end else begin
      if (bit_en) exp_bit = (q.size() > 0) ? q.pop_front() : 1'b1;
      if (bus_we && bus_addr == 8'h00 && fq.size() < 64) fq.push_back(bus_wdata);
      if (bus_we && bus_addr == 8'h02) begin
        if (bus_wdata[0]) begin q.delete(); fq.delete(); exp_bit = 1; end
        else if (bus_wdata[3] && q.size() == 0) build(bus_wdata[1]);
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    bit_en <= (cyc % 3 == 0);
    if (running) chk(tx_bit === exp_bit, "R1 R3 R4 R5 line bit", tx_bit, exp_bit);
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000 * 30) @(negedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_bit == 1 && fifo_ready == 1 && underrun == 0, "R1 reset state",
        {tx_bit, fifo_ready, underrun}, 3'b110);
    running = 1;
    repeat (20) @(negedge clk);

    // R2, R7: loaded bytes, no-op command writes
    wr(8'h00, 8'h11); wr(8'h00, 8'hC3);
    @(negedge clk);
    chk(fifo_ready == 0, "R7 ready low with bytes", fifo_ready, 0);
    wr(8'h02, 8'h00); wr(8'h02, 8'hF4);
    repeat (30) @(negedge clk);
    chk(fifo_ready == 0, "R2 no-op keeps FIFO", fifo_ready, 0);
    chk(tx_bit == 1, "R2 no-op keeps idle line", tx_bit, 1);

    // R3: start+end together
    wr(8'h02, 8'h0A);
    drain();
    chk(fifo_ready == 1, "R7 ready after frame", fifo_ready, 1);
    chk(underrun == 0, "R3 no underrun on ended frame", underrun, 0);

    // R4: stuffing-heavy bytes
    wr(8'h00, 8'hFF); wr(8'h00, 8'hFF); wr(8'h00, 8'h7E); wr(8'h00, 8'h3F); wr(8'h00, 8'hF8);
    wr(8'h02, 8'h0A);
    drain();

    // R5: empty frame, CRC all zeros
    wr(8'h02, 8'h0A);
    drain();

    // R10: 65 writes, only 64 kept
    for (int i = 0; i < 65; i++) wr(8'h00, 8'((i * 37 + 5) & 8'hFF));
    chk(fifo_ready == 0, "R10 FIFO loaded", fifo_ready, 0);
    wr(8'h02, 8'h0A);
    drain();
    chk(fifo_ready == 1, "R10 ready after full frame", fifo_ready, 1);

    // R9: continue during data phase
    for (int i = 0; i < 20; i++) wr(8'h00, 8'(i + 8'h40));
    wr(8'h02, 8'h0A);
    repeat (90) @(negedge clk);
    chk(q.size() > 0, "R9 frame in progress", q.size(), 1);
    wr(8'h02, 8'h08);
    drain();
    repeat (60) @(negedge clk);
    chk(tx_bit == 1, "R9 no extra frame", tx_bit, 1);

    // R6: reset mid-frame
    for (int i = 0; i < 10; i++) wr(8'h00, 8'(8'hA0 + i));
    wr(8'h02, 8'h0A);
    repeat (120) @(negedge clk);
    wr(8'h02, 8'h01);
    chk(tx_bit == 1, "R6 line ones after reset cmd", tx_bit, 1);
    chk(fifo_ready == 1, "R6 ready after reset cmd", fifo_ready, 1);
    repeat (60) @(negedge clk);
    wr(8'h00, 8'h5A); wr(8'h00, 8'hA5);
    wr(8'h02, 8'h0A);
    drain();

    // R8: underrun abort
    wr(8'h00, 8'h01); wr(8'h00, 8'hFE); wr(8'h00, 8'h1F);
    wr(8'h02, 8'h08);
    drain();
    chk(underrun == 1, "R8 underrun set", underrun, 1);
    chk(fifo_ready == 1, "R8 ready after abort", fifo_ready, 1);
    repeat (30) @(negedge clk);
    chk(underrun == 1, "R8 underrun sticky", underrun, 1);
    wr(8'h02, 8'h01);
    chk(underrun == 0, "R6 reset clears underrun", underrun, 0);
    repeat (20) @(negedge clk);

    running = 0;
    finish_run();
  end
endmodule